// File: doc/BRIEF.md
# I2C Target Controller with Host-Serviced Clock Stretching

This block is the target (slave) side of an I2C bus. It watches the open-drain SCL and SDA lines through two-flop synchronisers, finds START and STOP conditions, shifts in the address byte and compares it with a set of programmable 7-bit target addresses. After every event that needs a decision from the host, it holds SCL low and raises a pending flag. The events are a matched address, a received data byte, or a byte that must be supplied for a read. A two-bit service code says which event occurred. The bus stays frozen until the host writes the continue strobe.

On the host side there is a small register-style interface. It has a continue strobe, a transmit byte, a received byte, packed address slots with per-slot enables, an interrupt enable, and a DMA-mode bit. When DMA mode is set, data events go to a request/acknowledge pair and the pending flag stays low for them. A live not-stretching output tells the host when SCL is not held, which is the point at which entering a low-power state is safe.

Top module: `i2c_stall_slave`

## Requirements
- R1: A received 7-bit address counts as a hit when it equals any slot i whose enable bit addr_en[i] is 1. Slot i sits at slv_addr[7*i +: 7]. A miss raises no event, leaves SCL free and leaves SDA released in the acknowledge slot (NACK).
- R2: An address hit raises pending with svc_code 0 and holds SCL low. The R/W bit (LSB of the address byte, 0 = write, 1 = read) selects the direction that follows.
- R3: The service codes are 0 = address, 1 = received byte ready (rx_byte valid, MSB first on the bus), 2 = transmit byte needed. Code 3 never appears while pending is high.
- R4: Pending is cleared only by cont_wr while pending is high. A cont_wr with no service outstanding changes nothing.
- R5: While pending or dma_req is high, scl_oe is 1 and not_stretch is 0. Otherwise not_stretch is 1.
- R6: When the clock edge accepts a continue (cont_wr or dma_ack), pending or dma_req drops on that edge and SCL is released one edge later.
- R7: The target drives ACK (SDA low) in the acknowledge slot after a hit address and after every received data byte.
- R8: On a read, a transmit event (code 2) is raised after the address ACK and after each master ACK. tx_byte is captured on the continue and shifted out MSB first. A master NACK ends the transfer with no further event and SCL stays free.
- R9: With dma_en = 1, receive and transmit events assert dma_req (svc_code 1 or 2) instead of pending, and dma_ack acts as the continue. Address events still use pending.
- R10: irq is high exactly when pending and irq_en are both high.
- R11: A START or repeated START abandons any byte in progress and restarts address reception, leaving rx_byte unchanged. After a STOP, bits clocked without a new START raise no event.
- R12: After reset, pending, dma_req, irq, scl_oe and sda_oe are 0 and not_stretch is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| slv_addr | input | NADDR*AW | Packed target address slots, slot 0 in the low bits |
| addr_en | input | NADDR | Per-slot enable |
| cont_wr | input | 1 | Host continue strobe |
| tx_byte | input | DW | Byte to send on a read |
| rx_byte | output | DW | Last byte received |
| dma_en | input | 1 | Route data events to dma_req |
| dma_req | output | 1 | DMA service request for data events |
| dma_ack | input | 1 | DMA completion, acts as continue |
| irq_en | input | 1 | Interrupt enable for pending |
| irq | output | 1 | Interrupt request |
| pending | output | 1 | Host service needed |
| svc_code | output | 2 | Which service is needed |
| not_stretch | output | 1 | 1 when SCL is not being held |

## Verification
The bench uses the default parameters: four 7-bit slots, 8-bit data and two synchroniser stages. Every slot value is therefore reachable by a hit, and a fifth address, as well as a disabled slot, exercise the miss path. A bit-level bus master that honours stretching runs at about 24 system clocks per SCL half-period. This spacing makes the three-cycle synchroniser lag visible as a fixed delay before each stall. It also leaves room to measure the exact two-edge release after a continue.

// File: rtl/i2c_stall_pkg.sv
`timescale 1ns/1ps
package i2c_stall_pkg;

  // Service code reported to the host
  typedef enum logic [1:0] {
    SVC_ADDR = 2'd0,
    SVC_RX   = 2'd1,
    SVC_TX   = 2'd2
  } svc_e;

  // Bus-side phase of the target
  typedef enum logic [3:0] {
    PH_IDLE, PH_ADR, PH_ADR_WAIT, PH_ADR_ACK,
    PH_RX, PH_RX_WAIT, PH_RX_ACK,
    PH_TX, PH_TX_WAIT, PH_TX_ACK
  } phase_e;

  // Data events go to DMA only when enabled; address events never do
  function automatic logic route_to_dma(input logic is_data, input logic dma_on);
    return is_data & dma_on;
  endfunction

endpackage

// File: rtl/i2c_stall_sync.sv
`timescale 1ns/1ps
module i2c_stall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_stall_match.sv
`timescale 1ns/1ps
module i2c_stall_match #(
  parameter int NADDR = 4,
  parameter int AW    = 7
) (
  input  logic [NADDR*AW-1:0] slots,
  input  logic [NADDR-1:0]    en,
  input  logic [AW-1:0]       cand,
  output logic                hit
);
  logic [NADDR-1:0] slot_hit;

  for (genvar i = 0; i < NADDR; i++) begin : g_slot
    assign slot_hit[i] = en[i] && (slots[i*AW +: AW] == cand);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/i2c_stall_slave.sv
`timescale 1ns/1ps
module i2c_stall_slave
  import i2c_stall_pkg::*;
#(
  parameter int NADDR  = 4,
  parameter int AW     = 7,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                scl_oe,
  output logic                sda_oe,
  input  logic [NADDR*AW-1:0] slv_addr,
  input  logic [NADDR-1:0]    addr_en,
  input  logic                cont_wr,
  input  logic [DW-1:0]       tx_byte,
  output logic [DW-1:0]       rx_byte,
  input  logic                dma_en,
  output logic                dma_req,
  input  logic                dma_ack,
  input  logic                irq_en,
  output logic                irq,
  output logic                pending,
  output logic [1:0]          svc_code,
  output logic                not_stretch
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det, hit;
  phase_e ph;
  logic [DW-1:0] sh, txsh, rxb;
  logic [CW-1:0] cnt;
  logic rw_q, mack_q, pend_q, dreq_q, hold_q, sda_q;
  svc_e code_q;

  // Named internal events
  logic accept, ev_adr, ev_rx, ev_tx, ev_any;

  i2c_stall_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_stall_match #(.NADDR(NADDR), .AW(AW)) u_match (
    .slots(slv_addr), .en(addr_en), .cand(sh[AW:1]), .hit(hit)
  );

  always_comb begin
    accept = (cont_wr & pend_q) | (dma_ack & dreq_q);
    ev_adr = (ph == PH_ADR) && scl_fall && (cnt == FULL) && hit;
    ev_rx  = (ph == PH_RX) && scl_fall && (cnt == FULL);
    ev_tx  = scl_fall && (((ph == PH_ADR_ACK) && rw_q) || ((ph == PH_TX_ACK) && mack_q));
    ev_any = ev_adr | ev_rx | ev_tx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; sh <= '0; txsh <= '0; rxb <= '0; cnt <= '0;
      rw_q <= 1'b0; mack_q <= 1'b0; pend_q <= 1'b0; dreq_q <= 1'b0;
      hold_q <= 1'b0; sda_q <= 1'b0; code_q <= SVC_ADDR;
    end else if (start_det || stop_det) begin
      ph <= start_det ? PH_ADR : PH_IDLE;
      cnt <= '0; pend_q <= 1'b0; dreq_q <= 1'b0; hold_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      hold_q <= ev_any | pend_q | dreq_q;
      if (accept) begin
        pend_q <= 1'b0;
        dreq_q <= 1'b0;
      end
      if (ev_adr) begin
        pend_q <= 1'b1;
        code_q <= SVC_ADDR;
      end
      if (ev_rx || ev_tx) begin
        code_q <= ev_rx ? SVC_RX : SVC_TX;
        if (route_to_dma(1'b1, dma_en)) dreq_q <= 1'b1;
        else pend_q <= 1'b1;
      end
      case (ph)
        PH_ADR, PH_RX: begin
          if (scl_rise) begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end
          if (scl_fall && cnt == FULL) begin
            if (ph == PH_ADR) begin
              rw_q <= sh[0];
              ph   <= hit ? PH_ADR_WAIT : PH_IDLE;
            end else begin
              rxb <= sh;
              ph  <= PH_RX_WAIT;
            end
          end
        end
        PH_ADR_WAIT: if (accept) begin sda_q <= 1'b1; ph <= PH_ADR_ACK; end
        PH_RX_WAIT:  if (accept) begin sda_q <= 1'b1; ph <= PH_RX_ACK; end
        PH_ADR_ACK: if (scl_fall) begin
          sda_q <= 1'b0;
          cnt   <= '0;
          ph    <= rw_q ? PH_TX_WAIT : PH_RX;
        end
        PH_RX_ACK: if (scl_fall) begin
          sda_q <= 1'b0;
          cnt   <= '0;
          ph    <= PH_RX;
        end
        PH_TX_WAIT: if (accept) begin
          txsh  <= tx_byte;
          sda_q <= ~tx_byte[DW-1];
          cnt   <= '0;
          ph    <= PH_TX;
        end
        PH_TX: if (scl_fall) begin
          if (cnt == LAST) begin
            sda_q <= 1'b0;
            ph    <= PH_TX_ACK;
          end else begin
            cnt   <= cnt + 1'b1;
            txsh  <= txsh << 1;
            sda_q <= ~txsh[DW-2];
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) ph <= mack_q ? PH_TX_WAIT : PH_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign scl_oe      = hold_q;
  assign sda_oe      = sda_q;
  assign not_stretch = ~hold_q;
  assign pending     = pend_q;
  assign dma_req     = dreq_q;
  assign svc_code    = code_q;
  assign irq         = pend_q & irq_en;
  assign rx_byte     = rxb;
endmodule

// File: rtl/i2c_stall_chk.sv
`timescale 1ns/1ps
module i2c_stall_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pending,
  input logic       dma_req,
  input logic       scl_oe,
  input logic       cont_wr,
  input logic       dma_ack,
  input logic [1:0] svc_code
);
  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> svc_code != 2'd3);

  a_r5_hold_while_service: assert property (@(posedge clk) disable iff (!rst_n)
    (pending || dma_req) |-> scl_oe);

  a_r6_still_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pending) || $fell(dma_req)) |-> scl_oe);

  a_r6_release_next: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pending) || $fell(dma_req)) |=> !scl_oe);

  a_r4_clear_by_cont: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(cont_wr));

  a_r9_dma_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (!pending && svc_code != 2'd0));

  a_r9_dma_clear_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req) |-> $past(dma_ack));
endmodule

bind i2c_stall_slave i2c_stall_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pending(pending), .dma_req(dma_req),
  .scl_oe(scl_oe), .cont_wr(cont_wr), .dma_ack(dma_ack), .svc_code(svc_code)
);

// File: tb/tb_i2c_stall_slave.sv
`timescale 1ns/1ps
module tb_i2c_stall_slave;
  localparam int HALF = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_bus, sda_bus;
  logic scl_oe, sda_oe, cont_wr, dma_en, dma_req, dma_ack, irq_en, irq, pending, not_stretch;
  logic [27:0] slv_addr;
  logic [3:0]  addr_en;
  logic [7:0]  tx_byte, rx_byte;
  logic [1:0]  svc_code;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_stall_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .slv_addr(slv_addr), .addr_en(addr_en),
    .cont_wr(cont_wr), .tx_byte(tx_byte), .rx_byte(rx_byte), .dma_en(dma_en),
    .dma_req(dma_req), .dma_ack(dma_ack), .irq_en(irq_en), .irq(irq),
    .pending(pending), .svc_code(svc_code), .not_stretch(not_stretch)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  // {hit, addr[6:0], data[7:0]}
  localparam logic [15:0] VEC [0:4] = '{
    {1'b1, 7'h12, 8'hA5}, {1'b1, 7'h34, 8'h3C}, {1'b1, 7'h56, 8'h00},
    {1'b1, 7'h78, 8'hFF}, {1'b0, 7'h2A, 8'h5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r);
    m_sda = b; idle(HALF);
    scl_up(); idle(HALF);
    r = sda_bus;
    m_scl = 1'b0; idle(HALF);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(v[i], r);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      v[i] = r;
    end
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; idle(HALF);
    scl_up(); idle(HALF);
    m_sda = 1'b0; idle(HALF);
    m_scl = 1'b0; idle(HALF);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; idle(HALF);
    scl_up(); idle(HALF);
    m_sda = 1'b1; idle(HALF);
  endtask

  // Continue and check the release timing (R6)
  task automatic host_cont(input logic use_dma);
    if (use_dma) dma_ack = 1'b1; else cont_wr = 1'b1;
    @(negedge clk);
    cont_wr = 1'b0; dma_ack = 1'b0;
    chk("R6 service dropped", {pending, dma_req}, 0);
    chk("R6 still held one cycle", not_stretch, 0);
    @(negedge clk);
    chk("R6 released", not_stretch, 1);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] d, input logic hit);
    logic r;
    i2c_start();
    send_byte({a, 1'b0});
    if (hit) begin
      chk("R2 pending on addr", pending, 1);
      chk("R2 code addr", svc_code, 0);
      chk("R5 stretching", {not_stretch, scl_oe}, 2'b01);
      chk("R10 irq enabled", irq, 1);
      host_cont(1'b0);
      bit_io(1'b1, r);
      chk("R7 address ack", r, 0);
      send_byte(d);
      chk("R3 rx pending", pending, 1);
      chk("R3 rx code", svc_code, 1);
      chk("R3 rx data", rx_byte, d);
      host_cont(1'b0);
      bit_io(1'b1, r);
      chk("R7 data ack", r, 0);
    end else begin
      chk("R1 miss no event", pending, 0);
      chk("R1 miss no stretch", not_stretch, 1);
      bit_io(1'b1, r);
      chk("R1 miss nack", r, 1);
    end
    i2c_stop();
    chk("R11 idle after stop", {pending, not_stretch}, 2'b01);
  endtask

  initial begin
    logic r;
    logic [7:0] v;
    cont_wr = 1'b0; dma_en = 1'b0; dma_ack = 1'b0; irq_en = 1'b1;
    tx_byte = 8'h00;
    slv_addr = {7'h78, 7'h56, 7'h34, 7'h12};
    addr_en = 4'b1111;
    idle(5);
    chk("R12 reset outputs", {pending, dma_req, irq, scl_oe, sda_oe, not_stretch}, 6'b000001);
    rst_n = 1'b1;
    idle(5);

    // R4: continue with nothing pending is ignored
    cont_wr = 1'b1; @(negedge clk); cont_wr = 1'b0; idle(2);
    chk("R4 stray continue", {pending, not_stretch}, 2'b01);

    for (int k = 0; k < 5; k++) begin
      logic [15:0] e;
      e = VEC[k];
      wr_txn(e[14:8], e[7:0], e[15]);
    end

    // R1: disabled slot does not match
    addr_en = 4'b0111;
    wr_txn(7'h78, 8'h11, 1'b0);
    addr_en = 4'b1111;

    // R8: two-byte read, master ACK then NACK
    i2c_start();
    send_byte({7'h34, 1'b1});
    chk("R2 read addr code", svc_code, 0);
    host_cont(1'b0);
    bit_io(1'b1, r);
    chk("R7 read addr ack", r, 0);
    chk("R8 tx event after addr", {pending, svc_code}, 3'b110);
    tx_byte = 8'hC3;
    host_cont(1'b0);
    recv_byte(v);
    chk("R8 first byte", v, 8'hC3);
    bit_io(1'b0, r);
    chk("R8 tx event after ack", {pending, svc_code}, 3'b110);
    tx_byte = 8'h81;
    host_cont(1'b0);
    recv_byte(v);
    chk("R8 second byte", v, 8'h81);
    bit_io(1'b1, r);
    idle(10);
    chk("R8 nack no event", {pending, not_stretch}, 2'b01);
    i2c_stop();

    // R11: repeated START mid-byte restarts address reception
    i2c_start();
    send_byte({7'h56, 1'b0});
    host_cont(1'b0);
    bit_io(1'b1, r);
    bit_io(1'b1, r); bit_io(1'b0, r); bit_io(1'b1, r); bit_io(1'b0, r);
    i2c_start();
    send_byte({7'h12, 1'b1});
    chk("R11 restart gives addr code", {pending, svc_code}, 3'b100);
    chk("R11 rx_byte kept", rx_byte, 8'hFF);
    // R10: irq gated by enable
    irq_en = 1'b0; @(negedge clk);
    chk("R10 irq masked", irq, 0);
    irq_en = 1'b1;
    host_cont(1'b0);
    bit_io(1'b1, r);
    tx_byte = 8'h5E;
    host_cont(1'b0);
    recv_byte(v);
    chk("R8 read after restart", v, 8'h5E);
    bit_io(1'b1, r);
    i2c_stop();

    // R11: bits after STOP without START raise nothing
    m_scl = 1'b0; idle(HALF);
    send_byte({7'h12, 1'b0});
    bit_io(1'b1, r);
    idle(10);
    chk("R11 no start no event", {pending, not_stretch}, 2'b01);

    // R9: DMA mode routes data events to dma_req
    dma_en = 1'b1;
    i2c_start();
    send_byte({7'h78, 1'b0});
    chk("R9 addr still pending", {pending, dma_req, svc_code}, 4'b1000);
    host_cont(1'b0);
    bit_io(1'b1, r);
    send_byte(8'h96);
    chk("R9 dma request", {pending, dma_req, svc_code}, 4'b0101);
    chk("R9 stretch during dma", not_stretch, 0);
    host_cont(1'b1);
    bit_io(1'b1, r);
    chk("R9 dma data ack", r, 0);
    chk("R9 dma data", rx_byte, 8'h96);
    i2c_stop();
    dma_en = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule